// File: doc/BRIEF.md
# Parallel Programming Host Sequencer

This block is the host-side driver for the high-voltage parallel programming port of an on-chip nonvolatile memory. A host raises `start` for one cycle with an operation code. The block then produces the pin-level sequence on its own: the XTAL1 load strobe, the two action-select lines, the byte-select line, the write and output-enable strobes, and a shared 8-bit data bus. It also samples the device's ready/busy line. Three operations exist. A signature-byte read loads the read-signature command, loads an address low byte and strobes OE to capture one byte. A chip erase loads the erase command and issues one long write pulse. A fuse write loads the fuse command and the fuse byte, then issues one write pulse.

Every interval is a down-counter whose length is a nanosecond figure divided by the clock period `CLK_NS` and rounded up. The intervals are: 67 ns for setup, hold and strobe widths, 20 ns for OE-to-data and bus release, and the erase, fuse and ready-timeout windows. The long erase and fuse pulses outlast the device's internal ready time, so no busy pulse may appear. After such a pulse the sequencer therefore waits for ready to be high, not for an edge.

States: `S_IDLE`, `S_LD_SU` (byte, select lines and BS set up, XTAL1 low), `S_LD_HI` (XTAL1 high), `S_LD_HO` (XTAL1 low, values held), `S_RD_OE` (OE low, bus released), `S_RD_REL` (OE high, bus still released), `S_WR_LO` (write pulse low), `S_WR_RDY` (waiting for ready high, with timeout), `S_BS_HO` (BS held after ready) and `S_DONE`.

Transitions:
- `S_IDLE`→`S_LD_SU` on a valid start; `S_IDLE`→`S_DONE` on op code 3.
- `S_LD_SU`→`S_LD_HI`→`S_LD_HO` each on timer expiry.
- `S_LD_HO`→`S_LD_SU` when another load follows (read: command then address; fuse: command then data).
- `S_LD_HO`→`S_RD_OE` after the read's address load; `S_LD_HO`→`S_WR_LO` after the erase command or the fuse data load.
- `S_RD_OE`→`S_RD_REL`→`S_DONE`.
- `S_WR_LO`→`S_WR_RDY`; `S_WR_RDY`→`S_BS_HO` when ready is high; `S_WR_RDY`→`S_DONE` on timeout.
- `S_BS_HO`→`S_DONE`; `S_DONE`→`S_IDLE`.

Top module: `ppsq_top`

## Requirements
- R1: After reset, XTAL1 is 0, the select lines read 2'b11 (no action), BS is 1, WR and OE are 1 (inactive), and `busy` and `done` are 0.
- R2: A signature read (op 0) makes exactly two XTAL1 pulses. The first loads byte 0x08 with select lines 2'b10 (command). The second loads the `addr` byte with select lines 2'b00 (address). BS stays 0 for the whole operation.
- R3: For each load, the select lines, data byte and BS are stable for at least ceil(67/CLK_NS) cycles before XTAL1 rises. XTAL1 stays high exactly ceil(67/CLK_NS) cycles. The values are held for ceil(67/CLK_NS) cycles after XTAL1 falls, before any WR or OE strobe or the next load.
- R4: During a read, OE is low for exactly ceil(20/CLK_NS) cycles. The byte on DATA in the last of those cycles is returned on `rdata`.
- R5: The block never drives DATA while OE is low. It also leaves DATA released for at least ceil(20/CLK_NS) cycles after OE returns high.
- R6: A chip erase (op 1) loads the command byte 0x80 in one XTAL1 pulse. It then drives WR low for exactly ceil(T_ERASE_NS/CLK_NS) cycles.
- R7: A fuse write (op 2) loads command 0x40 with select 2'b10. It then loads the `wdata` byte with select 2'b01 (data). Finally it drives WR low for exactly ceil(T_FUSE_NS/CLK_NS) cycles.
- R8: After a write pulse the block waits for the ready line to be high, not for a low-going edge. BS stays low from before WR falls until at least ceil(67/CLK_NS) cycles after ready is seen high, and only then does `done` pulse.
- R9: If ready stays low for ceil(T_RDY_TO_NS/CLK_NS) cycles after the write pulse, the operation ends with `done` and `err`=1.
- R10: Op code 3 ends in the cycle after start with `done` and `err`=1, and with no XTAL1, WR or OE strobe.
- R11: `busy` is 1 from the cycle after an accepted start through the `done` cycle. `done` lasts one cycle. A start while busy is ignored. `err` is 0 after a successful operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request, accepted only when idle |
| op | input | 2 | 0 signature read, 1 chip erase, 2 fuse write, 3 invalid |
| addr | input | 8 | Signature address low byte |
| wdata | input | 8 | Fuse byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Ready timeout or invalid op; valid with done |
| rdata | output | 8 | Captured signature byte |
| prog_xtal1 | output | 1 | Load strobe |
| prog_xa | output | 2 | Action select: 00 address, 01 data, 10 command, 11 none |
| prog_bs | output | 1 | Byte select |
| prog_wr_n | output | 1 | Write strobe, active low |
| prog_oe_n | output | 1 | Output enable, active low |
| prog_rdy | input | 1 | Device ready (1) / busy (0) |
| prog_data | inout | 8 | Shared data bus |

## Verification
The in-RTL properties check the pin-level rules on every cycle:
- DATA is never driven while OE is low, and the release window holds before the bus is driven again.
- XTAL1 high width and load setup are held.
- WR and OE are never low together, and BS is low during a write.
- `done` lasts one cycle and is followed by idle.

Some behaviour depends on what the device answers, so only the directed scenarios can show it:
- the captured signature byte and the loaded command, address and data values;
- exact WR pulse lengths for erase and fuse;
- the BS hold after a late ready;
- the timeout error;
- rejection of a start while busy.

// File: rtl/ppsq_pkg.sv
package ppsq_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_LD_SU,
        S_LD_HI,
        S_LD_HO,
        S_RD_OE,
        S_RD_REL,
        S_WR_LO,
        S_WR_RDY,
        S_BS_HO,
        S_DONE
    } st_e;

    typedef enum logic [1:0] {
        PH_CMD,
        PH_ADR,
        PH_DAT
    } ph_e;

    localparam logic [1:0] OP_SIG   = 2'd0;
    localparam logic [1:0] OP_ERASE = 2'd1;
    localparam logic [1:0] OP_FUSE  = 2'd2;

    localparam logic [1:0] XA_ADR  = 2'b00;
    localparam logic [1:0] XA_DAT  = 2'b01;
    localparam logic [1:0] XA_CMD  = 2'b10;
    localparam logic [1:0] XA_NONE = 2'b11;

    function automatic int ns2cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/ppsq_timer.sv
module ppsq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          last
);

    logic [TW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    // the state entered with a load of N lasts N cycles
    assign last = (cnt_q <= TW'(1));

endmodule

// File: rtl/ppsq_ctrl.sv
module ppsq_ctrl
    import ppsq_pkg::*;
#(
    parameter int          TW        = 8,
    parameter int          N_STROBE  = 9,
    parameter int          N_OE      = 3,
    parameter int          N_ERASE   = 100,
    parameter int          N_FUSE    = 50,
    parameter int          N_TO      = 60,
    parameter logic [7:0]  CMD_SIG   = 8'h08,
    parameter logic [7:0]  CMD_ERASE = 8'h80,
    parameter logic [7:0]  CMD_FUSE  = 8'h40
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [1:0]    op,
    input  logic [7:0]    addr,
    input  logic [7:0]    wdata,
    input  logic          prog_rdy,
    input  logic [7:0]    rd_bus,
    input  logic          tmr_last,
    output logic          tmr_load,
    output logic [TW-1:0] tmr_val,
    output st_e           st,
    output ph_e           ph,
    output logic [7:0]    ld_byte,
    output logic          busy,
    output logic          done,
    output logic          err,
    output logic [7:0]    rdata
);

    localparam logic [TW-1:0] V_STROBE = TW'(N_STROBE);
    localparam logic [TW-1:0] V_OE     = TW'(N_OE);
    localparam logic [TW-1:0] V_ERASE  = TW'(N_ERASE);
    localparam logic [TW-1:0] V_FUSE   = TW'(N_FUSE);
    localparam logic [TW-1:0] V_TO     = TW'(N_TO);

    st_e        st_q, st_d;
    ph_e        ph_q, ph_d;
    logic [1:0] op_q;
    logic [7:0] addr_q, wdata_q, rdata_q;
    logic       err_q;
    logic       cap, to_err, accept;

    // next-state process
    always_comb begin
        st_d     = st_q;
        ph_d     = ph_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        cap      = 1'b0;
        to_err   = 1'b0;
        accept   = 1'b0;
        unique case (st_q)
            S_IDLE: begin
                if (start) begin
                    accept = 1'b1;
                    if (op == 2'd3) begin
                        st_d = S_DONE;
                    end else begin
                        st_d     = S_LD_SU;
                        ph_d     = PH_CMD;
                        tmr_load = 1'b1;
                        tmr_val  = V_STROBE;
                    end
                end
            end
            S_LD_SU: begin
                if (tmr_last) begin
                    st_d     = S_LD_HI;
                    tmr_load = 1'b1;
                    tmr_val  = V_STROBE;
                end
            end
            S_LD_HI: begin
                if (tmr_last) begin
                    st_d     = S_LD_HO;
                    tmr_load = 1'b1;
                    tmr_val  = V_STROBE;
                end
            end
            S_LD_HO: begin
                if (tmr_last) begin
                    tmr_load = 1'b1;
                    if (op_q == OP_SIG && ph_q == PH_CMD) begin
                        st_d    = S_LD_SU;
                        ph_d    = PH_ADR;
                        tmr_val = V_STROBE;
                    end else if (op_q == OP_SIG) begin
                        st_d    = S_RD_OE;
                        tmr_val = V_OE;
                    end else if (op_q == OP_FUSE && ph_q == PH_CMD) begin
                        st_d    = S_LD_SU;
                        ph_d    = PH_DAT;
                        tmr_val = V_STROBE;
                    end else if (op_q == OP_FUSE) begin
                        st_d    = S_WR_LO;
                        tmr_val = V_FUSE;
                    end else begin
                        st_d    = S_WR_LO;
                        tmr_val = V_ERASE;
                    end
                end
            end
            S_RD_OE: begin
                if (tmr_last) begin
                    cap      = 1'b1;
                    st_d     = S_RD_REL;
                    tmr_load = 1'b1;
                    tmr_val  = V_OE;
                end
            end
            S_RD_REL: begin
                if (tmr_last) begin
                    st_d = S_DONE;
                end
            end
            S_WR_LO: begin
                if (tmr_last) begin
                    st_d     = S_WR_RDY;
                    tmr_load = 1'b1;
                    tmr_val  = V_TO;
                end
            end
            S_WR_RDY: begin
                if (prog_rdy) begin
                    st_d     = S_BS_HO;
                    tmr_load = 1'b1;
                    tmr_val  = V_STROBE;
                end else if (tmr_last) begin
                    st_d   = S_DONE;
                    to_err = 1'b1;
                end
            end
            S_BS_HO: begin
                if (tmr_last) begin
                    st_d = S_DONE;
                end
            end
            S_DONE: begin
                st_d = S_IDLE;
            end
            default: begin
                st_d = S_IDLE;
            end
        endcase
    end

    // state register process
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            ph_q    <= PH_CMD;
            op_q    <= OP_SIG;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            st_q <= st_d;
            ph_q <= ph_d;
            if (accept) begin
                op_q    <= op;
                addr_q  <= addr;
                wdata_q <= wdata;
                err_q   <= (op == 2'd3);
            end
            if (cap) begin
                rdata_q <= rd_bus;
            end
            if (to_err) begin
                err_q <= 1'b1;
            end
        end
    end

    always_comb begin
        unique case (ph_q)
            PH_ADR:  ld_byte = addr_q;
            PH_DAT:  ld_byte = wdata_q;
            default: ld_byte = (op_q == OP_SIG)   ? CMD_SIG :
                               (op_q == OP_ERASE) ? CMD_ERASE : CMD_FUSE;
        endcase
    end

    assign st    = st_q;
    assign ph    = ph_q;
    assign busy  = (st_q != S_IDLE);
    assign done  = (st_q == S_DONE);
    assign err   = err_q;
    assign rdata = rdata_q;

    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
    AST_DONE_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R11
    AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> $stable(op_q) && $stable(addr_q) && $stable(wdata_q)); // R11
    AST_TIMEOUT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == S_WR_RDY && !prog_rdy && tmr_last) |=> (done && err)); // R9

endmodule

// File: rtl/ppsq_pins.sv
module ppsq_pins
    import ppsq_pkg::*;
#(
    parameter int N_STROBE = 9,
    parameter int N_OE     = 3
) (
    input  logic       clk,
    input  logic       rst_n,
    input  st_e        st,
    input  ph_e        ph,
    input  logic [7:0] ld_byte,
    output logic       xtal1,
    output logic [1:0] xa,
    output logic       bs,
    output logic       wr_n,
    output logic       oe_n,
    output logic [7:0] dout,
    output logic       doe
);

    logic loading;

    // output process: every pin decoded from the state register
    always_comb begin
        loading = (st == S_LD_SU) || (st == S_LD_HI) || (st == S_LD_HO);
        xtal1   = (st == S_LD_HI);
        bs      = (st == S_IDLE);
        wr_n    = (st != S_WR_LO);
        oe_n    = (st != S_RD_OE);
        doe     = loading;
        dout    = loading ? ld_byte : 8'h00;
        xa      = XA_NONE;
        if (loading) begin
            unique case (ph)
                PH_ADR:  xa = XA_ADR;
                PH_DAT:  xa = XA_DAT;
                default: xa = XA_CMD;
            endcase
        end
    end

    // interval trackers for the timing properties
    logic [15:0] hi_len, stab_len, oehi_len;
    logic        xt_q, doe_q;
    logic [11:0] sig_q;
    logic [11:0] sig_now;

    assign sig_now = {xa, dout, doe, bs};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_len   <= '0;
            stab_len <= 16'hFFFF;
            oehi_len <= 16'hFFFF;
            xt_q     <= 1'b0;
            doe_q    <= 1'b0;
            sig_q    <= {XA_NONE, 8'h00, 1'b0, 1'b1};
        end else begin
            xt_q  <= xtal1;
            doe_q <= doe;
            sig_q <= sig_now;
            if (!xtal1) hi_len <= '0;
            else if (hi_len != 16'hFFFF) hi_len <= hi_len + 1'b1;
            if (sig_now != sig_q) stab_len <= '0;
            else if (stab_len != 16'hFFFF) stab_len <= stab_len + 1'b1;
            if (!oe_n) oehi_len <= '0;
            else if (oehi_len != 16'hFFFF) oehi_len <= oehi_len + 1'b1;
        end
    end

    AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !doe); // R5
    AST_BUS_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (doe && !doe_q) |-> (oehi_len >= 16'(N_OE))); // R5
    AST_XTAL_MIN_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (xt_q && !xtal1) |-> (hi_len >= 16'(N_STROBE))); // R3
    AST_LOAD_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
        (xtal1 && !xt_q) |-> (stab_len >= 16'(N_STROBE - 1))); // R3
    AST_XTAL_HAS_ACTION: assert property (@(posedge clk) disable iff (!rst_n)
        xtal1 |-> (xa != XA_NONE)); // R2
    AST_WR_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(!wr_n && !oe_n)); // R8
    AST_BS_LOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !bs); // R8

endmodule

// File: rtl/ppsq_top.sv
module ppsq_top
    import ppsq_pkg::*;
#(
    parameter int          CLK_NS      = 8,
    parameter int          T_STROBE_NS = 67,
    parameter int          T_OE_NS     = 20,
    parameter int          T_ERASE_NS  = 10_000_000,
    parameter int          T_FUSE_NS   = 1_500_000,
    parameter int          T_RDY_TO_NS = 1_000_000,
    parameter logic [7:0]  CMD_SIG     = 8'h08,
    parameter logic [7:0]  CMD_ERASE   = 8'h80,
    parameter logic [7:0]  CMD_FUSE    = 8'h40
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [1:0] op,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic       busy,
    output logic       done,
    output logic       err,
    output logic [7:0] rdata,
    output logic       prog_xtal1,
    output logic [1:0] prog_xa,
    output logic       prog_bs,
    output logic       prog_wr_n,
    output logic       prog_oe_n,
    input  logic       prog_rdy,
    inout  wire  [7:0] prog_data
);

    localparam int N_STROBE = ns2cyc(T_STROBE_NS, CLK_NS);
    localparam int N_OE     = ns2cyc(T_OE_NS, CLK_NS);
    localparam int N_ERASE  = ns2cyc(T_ERASE_NS, CLK_NS);
    localparam int N_FUSE   = ns2cyc(T_FUSE_NS, CLK_NS);
    localparam int N_TO     = ns2cyc(T_RDY_TO_NS, CLK_NS);
    localparam int N_M1     = (N_ERASE > N_FUSE) ? N_ERASE : N_FUSE;
    localparam int N_M2     = (N_M1 > N_TO) ? N_M1 : N_TO;
    localparam int N_MAX    = (N_M2 > N_STROBE) ? N_M2 : N_STROBE;
    localparam int TW       = $clog2(N_MAX + 1) + 1;

    st_e           st;
    ph_e           ph;
    logic [7:0]    ld_byte, dout;
    logic          doe, tmr_load, tmr_last;
    logic [TW-1:0] tmr_val;

    ppsq_timer #(.TW(TW)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .last  (tmr_last)
    );

    ppsq_ctrl #(
        .TW(TW), .N_STROBE(N_STROBE), .N_OE(N_OE), .N_ERASE(N_ERASE),
        .N_FUSE(N_FUSE), .N_TO(N_TO), .CMD_SIG(CMD_SIG),
        .CMD_ERASE(CMD_ERASE), .CMD_FUSE(CMD_FUSE)
    ) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .op       (op),
        .addr     (addr),
        .wdata    (wdata),
        .prog_rdy (prog_rdy),
        .rd_bus   (prog_data),
        .tmr_last (tmr_last),
        .tmr_load (tmr_load),
        .tmr_val  (tmr_val),
        .st       (st),
        .ph       (ph),
        .ld_byte  (ld_byte),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .rdata    (rdata)
    );

    ppsq_pins #(.N_STROBE(N_STROBE), .N_OE(N_OE)) u_pins (
        .clk     (clk),
        .rst_n   (rst_n),
        .st      (st),
        .ph      (ph),
        .ld_byte (ld_byte),
        .xtal1   (prog_xtal1),
        .xa      (prog_xa),
        .bs      (prog_bs),
        .wr_n    (prog_wr_n),
        .oe_n    (prog_oe_n),
        .dout    (dout),
        .doe     (doe)
    );

    assign prog_data = doe ? dout : 8'bzzzz_zzzz;

endmodule

// File: tb/ppsq_top_tb_top.sv
`timescale 1ns/1ps
module ppsq_top_tb_top;

    localparam int CLK_NS   = 8;
    localparam int N_STROBE = 9;   // ceil(67/8)
    localparam int N_OE     = 3;   // ceil(20/8)
    localparam int N_ERASE  = 1250; // ceil(10000/8)
    localparam int N_FUSE   = 188;  // ceil(1500/8)
    localparam int N_TO     = 250;  // ceil(2000/8)

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [1:0] op = 2'd0;
    logic [7:0] addr = 8'h00, wdata = 8'h00;
    logic       busy, done, err;
    logic [7:0] rdata;
    logic       xtal1, bs, wr_n, oe_n;
    logic [1:0] xa;
    logic       rdy_r = 1'b1;
    wire  [7:0] prog_data;

    int nchk = 0, nerr = 0;

    always #(CLK_NS/2) clk = ~clk;

    ppsq_top #(
        .CLK_NS(CLK_NS), .T_ERASE_NS(10_000), .T_FUSE_NS(1_500), .T_RDY_TO_NS(2_000)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .addr(addr), .wdata(wdata),
        .busy(busy), .done(done), .err(err), .rdata(rdata),
        .prog_xtal1(xtal1), .prog_xa(xa), .prog_bs(bs), .prog_wr_n(wr_n),
        .prog_oe_n(oe_n), .prog_rdy(rdy_r), .prog_data(prog_data)
    );

    // device model
    logic [7:0] dev_addr = 8'h00;
    function automatic logic [7:0] sig_of(input logic [7:0] a);
        case (a[1:0])
            2'd0:    return 8'hA5;
            2'd1:    return 8'h3C;
            default: return 8'h71;
        endcase
    endfunction
    assign prog_data = !oe_n ? sig_of(dev_addr) : 8'bzzzz_zzzz;

    // monitors, sampled at the falling edge
    int         rdy_mode = 0;   // 0 always ready, 1 busy after WR, 2 stuck busy
    int         rdy_cnt = 0;
    int         xt_rises, xt_hi, xt_hi_min, xt_hi_max, stab, stab_min;
    int         wr_lo, wr_pulses, oe_lo, oe_hi_run, rel_at_done;
    int         rdy_hi_run, rdy_at_done, dones, bs_hi_in_op;
    logic [1:0] ld_xa [0:3];
    logic [7:0] ld_dat [0:3];
    logic       xt_p = 1'b0, wr_p = 1'b1;
    logic [11:0] sig_p = '0;

    task automatic clr_mon();
        xt_rises = 0; xt_hi = 0; xt_hi_min = 9999; xt_hi_max = 0;
        stab_min = 9999; wr_lo = 0; wr_pulses = 0; oe_lo = 0;
        rel_at_done = -1; rdy_at_done = -1; dones = 0; bs_hi_in_op = 0;
        for (int i = 0; i < 4; i++) begin ld_xa[i] = 2'b11; ld_dat[i] = 8'h00; end
    endtask

    initial begin clr_mon(); stab = 0; oe_hi_run = 0; rdy_hi_run = 0; end

    always @(negedge clk) begin
        if ({xa, prog_data, bs} !== sig_p) stab = 1; else stab = stab + 1;
        sig_p = {xa, prog_data, bs};
        if (xtal1 && !xt_p) begin
            if (xt_rises < 4) begin ld_xa[xt_rises] = xa; ld_dat[xt_rises] = prog_data; end
            xt_rises = xt_rises + 1;
            if (stab < stab_min) stab_min = stab;
        end
        if (xtal1) xt_hi = xt_hi + 1;
        if (!xtal1 && xt_p) begin
            if (xt_hi < xt_hi_min) xt_hi_min = xt_hi;
            if (xt_hi > xt_hi_max) xt_hi_max = xt_hi;
            xt_hi = 0;
        end
        xt_p = xtal1;
        if (!wr_n) wr_lo = wr_lo + 1;
        if (!wr_n && wr_p) wr_pulses = wr_pulses + 1;
        if (!oe_n) begin oe_lo = oe_lo + 1; oe_hi_run = 0; end
        else oe_hi_run = oe_hi_run + 1;
        if (busy && !done && bs) bs_hi_in_op = bs_hi_in_op + 1;
        if (rdy_r) rdy_hi_run = rdy_hi_run + 1; else rdy_hi_run = 0;
        if (done) begin
            dones = dones + 1;
            rel_at_done = oe_hi_run;
            rdy_at_done = rdy_hi_run;
        end
        // ready model driven here only
        if (rdy_mode == 2) rdy_r = 1'b0;
        else if (rdy_mode == 1 && wr_n && !wr_p) begin rdy_r = 1'b0; rdy_cnt = 40; end
        else if (rdy_cnt > 0) begin
            rdy_cnt = rdy_cnt - 1;
            if (rdy_cnt == 0) rdy_r = 1'b1;
        end else rdy_r = 1'b1;
        wr_p = wr_n;
        if (xtal1 && xa == 2'b00) dev_addr = prog_data;
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_start(input logic [1:0] o, input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        clr_mon();
        op = o; addr = a; wdata = d; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done(output int cyc);
        cyc = 1;
        while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(xtal1 == 1'b0, "R1 xtal1", int'(xtal1), 0);
        chk(xa == 2'b11, "R1 xa", int'(xa), 3);
        chk(bs == 1'b1, "R1 bs", int'(bs), 1);
        chk(wr_n && oe_n, "R1 wr/oe", int'({wr_n, oe_n}), 3);
        chk(!busy && !done, "R1 busy/done", int'({busy, done}), 0);
    endtask

    task automatic t_sig(input logic [7:0] a);
        int c;
        do_start(2'd0, a, 8'h00);
        chk(busy == 1'b1, "R11 busy after start", int'(busy), 1);
        wait_done(c);
        chk(xt_rises == 2, "R2 load count", xt_rises, 2);
        chk(ld_xa[0] == 2'b10 && ld_dat[0] == 8'h08, "R2 command load", int'({ld_xa[0], ld_dat[0]}), 'h208);
        chk(ld_xa[1] == 2'b00 && ld_dat[1] == a, "R2 address load", int'({ld_xa[1], ld_dat[1]}), int'({2'b00, a}));
        chk(bs_hi_in_op == 0, "R2 bs low", bs_hi_in_op, 0);
        chk(xt_hi_min == N_STROBE && xt_hi_max == N_STROBE, "R3 xtal high width", xt_hi_min, N_STROBE);
        chk(stab_min >= N_STROBE + 1, "R3 setup before xtal", stab_min, N_STROBE + 1);
        chk(oe_lo == N_OE, "R4 oe low width", oe_lo, N_OE);
        chk(rdata == sig_of(a), "R4 captured byte", int'(rdata), int'(sig_of(a)));
        chk(rel_at_done >= N_OE + 1, "R5 release window", rel_at_done, N_OE + 1);
        chk(err == 1'b0, "R11 err clear", int'(err), 0);
        chk(wr_pulses == 0, "R4 no write", wr_pulses, 0);
    endtask

    task automatic t_erase();
        int c;
        do_start(2'd1, 8'h00, 8'h00);
        wait_done(c);
        chk(xt_rises == 1 && ld_xa[0] == 2'b10 && ld_dat[0] == 8'h80, "R6 erase command", int'(ld_dat[0]), 'h80);
        chk(wr_pulses == 1 && wr_lo == N_ERASE, "R6 erase pulse", wr_lo, N_ERASE);
        chk(err == 1'b0, "R11 err clear", int'(err), 0);
    endtask

    task automatic t_fuse(input logic [7:0] d);
        int c;
        do_start(2'd2, 8'h00, d);
        wait_done(c);
        chk(xt_rises == 2 && ld_xa[0] == 2'b10 && ld_dat[0] == 8'h40, "R7 fuse command", int'(ld_dat[0]), 'h40);
        chk(ld_xa[1] == 2'b01 && ld_dat[1] == d, "R7 fuse data", int'(ld_dat[1]), int'(d));
        chk(wr_pulses == 1 && wr_lo == N_FUSE, "R7 fuse pulse", wr_lo, N_FUSE);
    endtask

    task automatic t_late_ready();
        int c;
        rdy_mode = 1;
        do_start(2'd2, 8'h00, 8'h5A);
        wait_done(c);
        rdy_mode = 0;
        chk(rdy_at_done >= N_STROBE + 1, "R8 bs hold after ready", rdy_at_done, N_STROBE + 1);
        chk(bs_hi_in_op == 0, "R8 bs low through hold", bs_hi_in_op, 0);
        chk(err == 1'b0, "R8 no error", int'(err), 0);
    endtask

    task automatic t_timeout();
        int c;
        rdy_mode = 2;
        repeat (2) @(negedge clk);
        do_start(2'd1, 8'h00, 8'h00);
        wait_done(c);
        rdy_mode = 0;
        chk(dones == 1 && err == 1'b1, "R9 timeout error", int'(err), 1);
        chk(c >= N_ERASE + N_TO, "R9 timeout length", c, N_ERASE + N_TO);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_bad_op();
        do_start(2'd3, 8'h00, 8'h00);
        chk(done == 1'b1 && err == 1'b1, "R10 immediate error", int'({done, err}), 3);
        repeat (4) @(negedge clk);
        chk(xt_rises == 0 && wr_pulses == 0 && oe_lo == 0, "R10 no strobes", xt_rises + wr_pulses + oe_lo, 0);
    endtask

    task automatic t_busy_start();
        int c;
        do_start(2'd0, 8'h01, 8'h00);
        repeat (5) @(negedge clk);
        op = 2'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done(c);
        repeat (20) @(negedge clk);
        chk(dones == 1, "R11 single done", dones, 1);
        chk(wr_pulses == 0 && xt_rises == 2, "R11 start while busy ignored", wr_pulses, 0);
        chk(rdata == 8'h3C, "R11 original read kept", int'(rdata), 'h3C);
        chk(!busy, "R11 idle after done", int'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_sig(8'h00);
        t_sig(8'h01);
        t_sig(8'h02);
        t_erase();
        t_fuse(8'hC3);
        t_late_ready();
        t_timeout();
        t_fuse(8'h0F);
        t_bad_op();
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin
        repeat (150_000) @(posedge clk);
        nchk++; nerr++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule